// File: doc/BRIEF.md
# LED Blink Pattern Generator with Auto-Stop

This block drives a single LED pin with a repeating on/off pattern. An incoming tick strobe is divided by a power of two chosen by a four-bit time-base field. Each divided step advances a twelve-bit period counter. The LED is lit during the leading part of every period, and a twelve-bit duty value sets how long that part is. Software sets up the pattern by writing four registers: control, period, duty and stop count. It starts the pattern by setting the enable bit.

When auto-stop is armed, the block counts the periods it has completed. Once that count reaches the programmed stop value, the block turns itself off, clears its own enable bit and latches an interrupt flag. The flag drives the interrupt output unless the mask bit is set. Any write to the control register clears the flag. New period and duty values are held back until the running period ends, so a pattern that is already running never shows a partial or mixed period.

Top module: `blink_led_gen`

## Requirements
- R1: After reset, `led_o` and `irq_o` are 0 and every register reads back as 0.
- R2: Registers are selected by `wr_addr[3:2]`/`rd_addr[3:2]`: 0 is control (7 bits), 1 is period (12 bits), 2 is duty (12 bits) and 3 is stop count (16 bits). Unused upper data bits are dropped on a write and read back as 0.
- R3: Control bit 4 is the enable bit. While it is 1, `led_o` is 1 exactly when the period counter is below the active duty. The counter starts at 0 on enable, advances by one on each divided step, and wraps to 0 after it reaches period−1. A period of 0 behaves as a period of 1.
- R4: A duty of 0 keeps `led_o` at 0. A duty equal to or above the period keeps `led_o` at 1 for as long as the block is enabled.
- R5: Control bits 3:0 hold a time-base value n. For n ≤ 13, a divided step occurs on every 2^(13−n)-th tick, counted from enable.
- R6: A time-base value from 14 to 15 behaves exactly like 13, which gives one step per tick.
- R7: A period or duty value written while the block is enabled takes effect only at the next period wrap. While the block is disabled, a written value is used from the moment of enable.
- R8: When control bit 5 (auto-stop) is 1 and the number of periods completed since enable reaches the nonzero stop count, the block does three things on that period's wrap: it clears the enable bit, drives `led_o` to 0 and sets the interrupt flag.
- R9: While control bit 6 (mask) is 1, `irq_o` is 0.
- R10: Any write to the control register clears the interrupt flag.
- R11: Clearing the enable bit forces `led_o` to 0 and restarts the divider, the period counter and the period count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time-base tick strobe, one clock wide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write byte offset |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Read byte offset |
| rd_data | output | 16 | Read data (combinational) |
| led_o | output | 1 | LED drive |
| irq_o | output | 1 | Auto-stop interrupt |

## Verification
The hardest case to reach is a period or duty write that lands in the middle of a period. The stimulus enables a four-step period and writes a larger duty one step in. It then ticks the block one step at a time and checks that the old duty holds until the wrap and the new duty appears right after it. Auto-stop is reached by arming a stop count of three periods and ticking until the wrap on which the block disables itself. The same sequence is then repeated with the mask bit set.

// File: rtl/blink_led_pkg.sv
`timescale 1ns/1ps
package blink_led_pkg;
  localparam int TB_W   = 4;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 4;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_PER  = 2'd1,
    SEL_DUTY = 2'd2,
    SEL_STOP = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic            mask;
    logic            autostop;
    logic            en;
    logic [TB_W-1:0] tb;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/blink_prescale.sv
`timescale 1ns/1ps
module blink_prescale
  import blink_led_pkg::*;
#(
  parameter int TB_MAX = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            tick_i,
  input  logic [TB_W-1:0] tb,
  output logic            step_o
);
  localparam int CW = TB_MAX;

  logic [CW-1:0]   cnt_q, cnt_d;
  logic [TB_W-1:0] sel;
  logic [CW-1:0]   mask;

  always_comb begin
    sel    = (tb > TB_W'(TB_MAX)) ? TB_W'(TB_MAX) : tb;
    mask   = {CW{1'b1}} >> sel;
    step_o = run & tick_i & ((cnt_q & mask) == mask);
    if (!run)        cnt_d = '0;
    else if (tick_i) cnt_d = cnt_q + 1'b1;
    else             cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/blink_pattern.sv
`timescale 1ns/1ps
module blink_pattern #(
  parameter int PER_W  = 12,
  parameter int STOP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              autostop,
  input  logic              step,
  input  logic [PER_W-1:0]  per_reg,
  input  logic [PER_W-1:0]  duty_reg,
  input  logic [STOP_W-1:0] stop_reg,
  output logic              led_o,
  output logic              stop_o
);
  logic [PER_W-1:0]  pcnt_q, pcnt_d;
  logic [PER_W-1:0]  act_per_q, act_per_d;
  logic [PER_W-1:0]  act_duty_q, act_duty_d;
  logic [STOP_W-1:0] done_q, done_d;
  logic [PER_W:0]    pnext;
  logic [STOP_W:0]   done_next;
  logic              wrap;

  always_comb begin
    pnext     = {1'b0, pcnt_q} + 1'b1;
    done_next = {1'b0, done_q} + 1'b1;
    wrap      = step & (pnext >= {1'b0, act_per_q});
    stop_o    = run & autostop & wrap & (done_next == {1'b0, stop_reg});
    led_o     = run & (pcnt_q < act_duty_q);

    pcnt_d     = pcnt_q;
    act_per_d  = act_per_q;
    act_duty_d = act_duty_q;
    done_d     = done_q;
    if (!run) begin
      pcnt_d     = '0;
      done_d     = '0;
      act_per_d  = per_reg;
      act_duty_d = duty_reg;
    end else if (wrap) begin
      pcnt_d     = '0;
      done_d     = done_next[STOP_W-1:0];
      act_per_d  = per_reg;
      act_duty_d = duty_reg;
    end else if (step) begin
      pcnt_d = pnext[PER_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q     <= '0;
      act_per_q  <= '0;
      act_duty_q <= '0;
      done_q     <= '0;
    end else begin
      pcnt_q     <= pcnt_d;
      act_per_q  <= act_per_d;
      act_duty_q <= act_duty_d;
      done_q     <= done_d;
    end
  end
endmodule

// File: rtl/blink_regs.sv
`timescale 1ns/1ps
module blink_regs
  import blink_led_pkg::*;
#(
  parameter int PER_W  = 12,
  parameter int STOP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              stop_i,
  output ctrl_t             ctrl,
  output logic [PER_W-1:0]  per,
  output logic [PER_W-1:0]  duty,
  output logic [STOP_W-1:0] stop_val,
  output logic              flag,
  output logic              wr_ctrl,
  output logic [DATA_W-1:0] rd_data
);
  ctrl_t             ctrl_d;
  logic [PER_W-1:0]  per_d, duty_d;
  logic [STOP_W-1:0] stop_d;
  logic              flag_d;
  reg_sel_e          wsel, rsel;

  always_comb begin
    wsel    = reg_sel_e'(wr_addr[3:2]);
    rsel    = reg_sel_e'(rd_addr[3:2]);
    wr_ctrl = wr_en && (wsel == SEL_CTRL);

    ctrl_d = ctrl;
    if (wr_ctrl)     ctrl_d = ctrl_t'(wr_data[CTRL_W-1:0]);
    else if (stop_i) ctrl_d.en = 1'b0;

    per_d  = (wr_en && wsel == SEL_PER)  ? wr_data[PER_W-1:0]  : per;
    duty_d = (wr_en && wsel == SEL_DUTY) ? wr_data[PER_W-1:0]  : duty;
    stop_d = (wr_en && wsel == SEL_STOP) ? wr_data[STOP_W-1:0] : stop_val;

    if (wr_ctrl)     flag_d = 1'b0;
    else if (stop_i) flag_d = 1'b1;
    else             flag_d = flag;

    case (rsel)
      SEL_CTRL: rd_data = DATA_W'(ctrl);
      SEL_PER:  rd_data = DATA_W'(per);
      SEL_DUTY: rd_data = DATA_W'(duty);
      default:  rd_data = DATA_W'(stop_val);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      per      <= '0;
      duty     <= '0;
      stop_val <= '0;
      flag     <= 1'b0;
    end else begin
      ctrl     <= ctrl_d;
      per      <= per_d;
      duty     <= duty_d;
      stop_val <= stop_d;
      flag     <= flag_d;
    end
  end
endmodule

// File: rtl/blink_led_gen.sv
`timescale 1ns/1ps
module blink_led_gen
  import blink_led_pkg::*;
#(
  parameter int PER_W  = 12,
  parameter int STOP_W = 16,
  parameter int TB_MAX = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              led_o,
  output logic              irq_o
);
  ctrl_t             ctrl;
  logic [PER_W-1:0]  per, duty;
  logic [STOP_W-1:0] stop_val;
  logic              flag, wr_ctrl, stop_pulse, step;

  blink_regs #(.PER_W(PER_W), .STOP_W(STOP_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .stop_i   (stop_pulse),
    .ctrl     (ctrl),
    .per      (per),
    .duty     (duty),
    .stop_val (stop_val),
    .flag     (flag),
    .wr_ctrl  (wr_ctrl),
    .rd_data  (rd_data)
  );

  blink_prescale #(.TB_MAX(TB_MAX)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (ctrl.en),
    .tick_i (tick_i),
    .tb     (ctrl.tb),
    .step_o (step)
  );

  blink_pattern #(.PER_W(PER_W), .STOP_W(STOP_W)) u_pat (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (ctrl.en),
    .autostop (ctrl.autostop),
    .step     (step),
    .per_reg  (per),
    .duty_reg (duty),
    .stop_reg (stop_val),
    .led_o    (led_o),
    .stop_o   (stop_pulse)
  );

  assign irq_o = flag & ~ctrl.mask;
endmodule

// File: rtl/blink_led_chk.sv
`timescale 1ns/1ps
module blink_led_chk (
  input logic clk,
  input logic rst_n,
  input logic led_o,
  input logic irq_o,
  input logic en,
  input logic mask,
  input logic flag,
  input logic stop,
  input logic step,
  input logic wr_en,
  input logic wr_ctrl
);
  a_r11_led_off_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !led_o);

  a_r8_stop_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !wr_ctrl) |=> (flag && !en && !led_o));

  a_r10_write_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> !flag);

  a_r8_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !wr_ctrl) |=> flag);

  a_r5_led_moves_on_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !wr_en) |=> $stable(led_o));

  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask && !wr_ctrl) |=> (mask -> !irq_o));
endmodule

bind blink_led_gen blink_led_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .led_o   (led_o),
  .irq_o   (irq_o),
  .en      (ctrl.en),
  .mask    (ctrl.mask),
  .flag    (flag),
  .stop    (stop_pulse),
  .step    (step),
  .wr_en   (wr_en),
  .wr_ctrl (wr_ctrl)
);

// File: tb/blink_led_gen_tb.sv
`timescale 1ns/1ps
module blink_led_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        led_o, irq_o;

  always #2.5 clk = ~clk;

  blink_led_gen u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .led_o(led_o), .irq_o(irq_o)
  );

  typedef struct {
    logic  led;
    logic  irq;
    string req;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 0;

  // monitor: compares queued expectations 1 ns after each falling edge
  always @(negedge clk) begin
    #1;
    while (q.size() > 0) begin
      cur = q.pop_front();
      n_chk++;
      if (led_o !== cur.led || irq_o !== cur.irq) begin
        n_fail++;
        $display("FAIL %s: led=%b irq=%b expected led=%b irq=%b",
                 cur.req, led_o, irq_o, cur.led, cur.irq);
      end
    end
  end

  task automatic expect_out(input logic l, input logic i, input string r);
    exp_t e;
    e.led = l; e.irq = i; e.req = r;
    q.push_back(e);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tk(input logic l, input logic i, input string r);
    @(negedge clk);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    expect_out(l, i, r);
  endtask

  task automatic rdchk(input logic [3:0] a, input logic [15:0] exp, input string r);
    rd_addr = a;
    #0.5;
    n_chk++;
    if (rd_data !== exp) begin
      n_fail++;
      $display("FAIL %s: rd[%0h]=%h expected %h", r, a, rd_data, exp);
    end
  endtask

  task automatic run_pat(input int p, input int d, input int nt, input string r);
    for (int s = 1; s <= nt; s++) tk(((s % p) < d), 1'b0, r);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    expect_out(1'b0, 1'b0, "R1");
    rdchk(4'h0, 16'h0000, "R1");
    rdchk(4'h4, 16'h0000, "R1");
    rdchk(4'hC, 16'h0000, "R1");

    // R2 width truncation on write/readback
    wr(4'h4, 16'hFABC);
    rdchk(4'h4, 16'h0ABC, "R2");
    wr(4'h0, 16'hFF80);
    rdchk(4'h0, 16'h0000, "R2");
    wr(4'hC, 16'hBEEF);
    rdchk(4'hC, 16'hBEEF, "R2");

    // R3 basic pattern: period 4, duty 1, one step per tick
    wr(4'h4, 16'd4);
    wr(4'h8, 16'd1);
    wr(4'h0, 16'h001D);
    expect_out(1'b1, 1'b0, "R3");
    run_pat(4, 1, 9, "R3");

    // R11 disable forces LED off
    wr(4'h0, 16'h000D);
    expect_out(1'b0, 1'b0, "R11");
    tk(1'b0, 1'b0, "R11");

    // R4 duty 0 and duty above period
    wr(4'h8, 16'd0);
    wr(4'h0, 16'h001D);
    expect_out(1'b0, 1'b0, "R4");
    run_pat(4, 0, 5, "R4");
    wr(4'h0, 16'h000D);
    wr(4'h8, 16'd6);
    wr(4'h0, 16'h001D);
    expect_out(1'b1, 1'b0, "R4");
    run_pat(4, 6, 5, "R4");

    // R5 time base 11 -> one step per 4 ticks
    wr(4'h0, 16'h000D);
    wr(4'h4, 16'd2);
    wr(4'h8, 16'd1);
    wr(4'h0, 16'h001B);
    expect_out(1'b1, 1'b0, "R5");
    for (int t = 1; t <= 12; t++) tk((((t / 4) % 2) < 1), 1'b0, "R5");

    // R6 time base 15 behaves like 13
    wr(4'h0, 16'h000D);
    wr(4'h0, 16'h001F);
    expect_out(1'b1, 1'b0, "R6");
    run_pat(2, 1, 6, "R6");

    // R7 duty written mid-period applies at the wrap
    wr(4'h0, 16'h000D);
    wr(4'h4, 16'd4);
    wr(4'h8, 16'd1);
    wr(4'h0, 16'h001D);
    expect_out(1'b1, 1'b0, "R7");
    tk(1'b0, 1'b0, "R7");
    wr(4'h8, 16'd3);
    expect_out(1'b0, 1'b0, "R7");
    tk(1'b0, 1'b0, "R7");
    tk(1'b0, 1'b0, "R7");
    tk(1'b1, 1'b0, "R7");
    tk(1'b1, 1'b0, "R7");
    tk(1'b1, 1'b0, "R7");
    tk(1'b0, 1'b0, "R7");

    // R8 auto-stop after 3 periods of 2 steps
    wr(4'h0, 16'h000D);
    wr(4'h4, 16'd2);
    wr(4'h8, 16'd1);
    wr(4'hC, 16'd3);
    wr(4'h0, 16'h003D);
    expect_out(1'b1, 1'b0, "R8");
    for (int s = 1; s <= 5; s++) tk(((s % 2) < 1), 1'b0, "R8");
    tk(1'b0, 1'b1, "R8");
    rdchk(4'h0, 16'h002D, "R8");
    tk(1'b0, 1'b1, "R8");

    // R10 control write clears the flag
    wr(4'h0, 16'h002D);
    expect_out(1'b0, 1'b0, "R10");

    // R9 masked: stop occurs but irq stays low
    wr(4'h0, 16'h007D);
    expect_out(1'b1, 1'b0, "R9");
    for (int s = 1; s <= 5; s++) tk(((s % 2) < 1), 1'b0, "R9");
    tk(1'b0, 1'b0, "R9");
    rdchk(4'h0, 16'h006D, "R9");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule